// File: doc/BRIEF.md
# Calendar Clock Counter

This block keeps wall-clock time and calendar date: seconds, minutes, hours, day of week, date, month and a two-digit year. A reference enable, asserted once per 32.768 kHz period, is divided down to a one-second advance. The advance ripples from seconds through to the year. It follows the length of each month, and February has 29 days in years divisible by four.

Software loads any field through a register write port and reads any field back through a combinational read port. All fields are presented in BCD. A control bit picks how the hour register looks. In 24-hour form it shows 00 to 23. In 12-hour form it shows 1 to 12 plus an afternoon flag.

Reset stands for a complete loss of power. After it the counter holds still until software writes one of the time registers. Every write also restarts the sub-second divider, so the next advance comes one full second after the write.

Top module: `calendar_clock`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hour 0x00, date 0x01, month 0x01, year 0x00, weekday 0x00 and control 0x00 (24-hour form), and `halted` is 1.
- R2: While `halted` is 1, no field changes on reference ticks. A write to any of addresses 0 to 6 clears `halted`. A write to the control address 7 leaves it set.
- R3: While running, the seconds field advances by one after every DIV reference ticks and does not advance while `ref_tick` is low.
- R4: An accepted write sets the divider back to zero, so the next advance occurs on the DIV-th `ref_tick` after the write cycle.
- R5: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. Each wrap advances the next field up, and the hour wrap advances the date.
- R6: April, June, September and November roll over after date 30. The other months, except February, roll over after 31. The month wraps from 12 to 1.
- R7: February rolls over after 29 when the year value is divisible by 4, and after 28 otherwise. The year wraps from 99 to 00 when December ends.
- R8: The weekday field (address 6, value 0 to 6) advances together with the date and wraps from 6 to 0.
- R9: With control bit 0 clear, the hour register (address 2) reads and writes the hour as BCD 00 to 23.
- R10: With control bit 0 set, hour bits [4:0] hold BCD 1 to 12 and bit 5 is 1 for the afternoon. Midnight reads 0x12 and noon reads 0x32. The flag flips on the 11:59:59 to 12:00:00 advance. Switching the form converts the displayed hour of the stored time.
- R11: Address map for `rd_addr` and `wr_addr`: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 weekday, all BCD; 7 control, with bit 0 the 12-hour select.
- R12: `wr_ready` is always 1. A write cycle never advances time, so a burst of writes longer than a second leaves the fields at the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset, models total power loss |
| ref_tick | input | 1 | One-cycle enable per reference period |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data for `rd_addr`, combinational |
| halted | output | 1 | Counting held off since reset |

## Verification
The write port never applies back-pressure, so a write takes effect on the cycle `wr_valid` is seen. The range checks on the fields assume software writes only legal BCD values: minutes and seconds below 60, and a date that fits its month and year. The stimulus keeps within these limits and writes only calendar-valid times. It reaches every rollover by loading the second just before the rollover and then waiting one period, rather than counting through whole days.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int FIELD_W = 7;
  localparam int NREG    = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_DATE  = 3'd3,
    REG_MONTH = 3'd4,
    REG_YEAR  = 3'd5,
    REG_DOW   = 3'd6,
    REG_CTRL  = 3'd7
  } cal_reg_e;

  function automatic logic [FIELD_W-1:0] bcd_to_bin(input logic [DATA_W-1:0] d);
    return FIELD_W'(d[7:4]) * FIELD_W'(10) + FIELD_W'(d[3:0]);
  endfunction

  function automatic logic [DATA_W-1:0] bin_to_bcd(input logic [FIELD_W-1:0] v);
    return {4'(v / FIELD_W'(10)), 4'(v % FIELD_W'(10))};
  endfunction

  function automatic logic [FIELD_W-1:0] month_len(input logic [FIELD_W-1:0] m,
                                                    input logic leap);
    case (m)
      7'd2:                  return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: return 7'd30;
      default:               return 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_tick_div.sv
module cal_tick_div #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ref_tick,
  input  logic restart,
  output logic sec_tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last  = (cnt_q == LAST);
  assign sec_tick = run && ref_tick && !restart && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (run && ref_tick) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               ld_sec,
  input  logic               ld_min,
  input  logic               ld_hour,
  input  logic [FIELD_W-1:0] ld_val,
  output logic [FIELD_W-1:0] sec,
  output logic [FIELD_W-1:0] min,
  output logic [FIELD_W-1:0] hour,
  output logic               day_tick
);
  logic sec_end, min_end, hour_end;

  assign sec_end  = (sec >= 7'd59);
  assign min_end  = (min >= 7'd59);
  assign hour_end = (hour >= 7'd23);
  assign day_tick = tick && sec_end && min_end && hour_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec  <= '0;
      min  <= '0;
      hour <= '0;
    end else begin
      if (ld_sec)                  sec  <= ld_val;
      else if (tick)               sec  <= sec_end ? '0 : sec + 1'b1;
      if (ld_min)                  min  <= ld_val;
      else if (tick && sec_end)    min  <= min_end ? '0 : min + 1'b1;
      if (ld_hour)                 hour <= ld_val;
      else if (tick && sec_end && min_end)
                                   hour <= hour_end ? '0 : hour + 1'b1;
    end
  end
endmodule

// File: rtl/cal_date_core.sv
module cal_date_core
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               day_tick,
  input  logic               ld_date,
  input  logic               ld_month,
  input  logic               ld_year,
  input  logic               ld_dow,
  input  logic [FIELD_W-1:0] ld_val,
  output logic [FIELD_W-1:0] date,
  output logic [FIELD_W-1:0] month,
  output logic [FIELD_W-1:0] year,
  output logic [FIELD_W-1:0] dow
);
  logic               leap;
  logic [FIELD_W-1:0] last_day;
  logic               month_end, year_end;

  assign leap      = (year[1:0] == 2'b00);
  assign last_day  = month_len(month, leap);
  assign month_end = (date >= last_day);
  assign year_end  = month_end && (month >= 7'd12);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date  <= 7'd1;
      month <= 7'd1;
      year  <= '0;
      dow   <= '0;
    end else begin
      if (ld_date)                    date  <= ld_val;
      else if (day_tick)              date  <= month_end ? 7'd1 : date + 1'b1;
      if (ld_month)                   month <= ld_val;
      else if (day_tick && month_end) month <= (month >= 7'd12) ? 7'd1 : month + 1'b1;
      if (ld_year)                    year  <= ld_val;
      else if (day_tick && year_end)  year  <= (year >= 7'd99) ? '0 : year + 1'b1;
      if (ld_dow)                     dow   <= ld_val;
      else if (day_tick)              dow   <= (dow >= 7'd6) ? '0 : dow + 1'b1;
    end
  end
endmodule

// File: rtl/cal_reg_map.sv
module cal_reg_map
  import cal_pkg::*;
(
  input  logic               wr_valid,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  input  logic               mode12,
  input  logic [FIELD_W-1:0] sec,
  input  logic [FIELD_W-1:0] min,
  input  logic [FIELD_W-1:0] hour,
  input  logic [FIELD_W-1:0] date,
  input  logic [FIELD_W-1:0] month,
  input  logic [FIELD_W-1:0] year,
  input  logic [FIELD_W-1:0] dow,
  output logic [NREG-1:0]    ld,
  output logic [FIELD_W-1:0] ld_val,
  output logic [DATA_W-1:0]  rd_data
);
  for (genvar g = 0; g < NREG; g++) begin : g_ld
    assign ld[g] = wr_valid && (wr_addr == ADDR_W'(g));
  end

  logic [FIELD_W-1:0] wr_h12, wr_hour12, wr_hour;
  assign wr_h12    = bcd_to_bin({3'b000, wr_data[4:0]});
  assign wr_hour12 = ((wr_h12 == 7'd12) ? 7'd0 : wr_h12) + (wr_data[5] ? 7'd12 : 7'd0);
  assign wr_hour   = mode12 ? wr_hour12 : bcd_to_bin(wr_data);

  always_comb begin
    if (wr_addr == REG_HOUR) ld_val = wr_hour;
    else                     ld_val = bcd_to_bin(wr_data);
  end

  logic [FIELD_W-1:0] rd_h12;
  logic               rd_pm;
  logic [DATA_W-1:0]  rd_hour;
  assign rd_pm   = (hour >= 7'd12);
  assign rd_h12  = (hour == 7'd0) ? 7'd12 : ((hour > 7'd12) ? hour - 7'd12 : hour);
  assign rd_hour = mode12 ? (bin_to_bcd(rd_h12) | {2'b00, rd_pm, 5'b00000})
                          : bin_to_bcd(hour);

  always_comb begin
    case (rd_addr)
      REG_SEC:   rd_data = bin_to_bcd(sec);
      REG_MIN:   rd_data = bin_to_bcd(min);
      REG_HOUR:  rd_data = rd_hour;
      REG_DATE:  rd_data = bin_to_bcd(date);
      REG_MONTH: rd_data = bin_to_bcd(month);
      REG_YEAR:  rd_data = bin_to_bcd(year);
      REG_DOW:   rd_data = bin_to_bcd(dow);
      default:   rd_data = {{(DATA_W-1){1'b0}}, mode12};
    endcase
  end
endmodule

// File: rtl/calendar_clock.sv
module calendar_clock
  import cal_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              halted
);
  logic               halted_q, mode_q, sec_tick, day_tick;
  logic [NREG-1:0]    ld;
  logic [FIELD_W-1:0] ld_val;
  logic [FIELD_W-1:0] sec_q, min_q, hour_q, date_q, month_q, year_q, dow_q;

  assign wr_ready = 1'b1;
  assign halted   = halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q <= 1'b1;
      mode_q   <= 1'b0;
    end else begin
      if (wr_valid && (wr_addr != REG_CTRL)) halted_q <= 1'b0;
      if (ld[REG_CTRL])                      mode_q   <= wr_data[0];
    end
  end

  cal_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(!halted_q), .ref_tick(ref_tick),
    .restart(wr_valid), .sec_tick(sec_tick)
  );

  cal_reg_map u_map (
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .mode12(mode_q), .sec(sec_q), .min(min_q), .hour(hour_q), .date(date_q),
    .month(month_q), .year(year_q), .dow(dow_q), .ld(ld), .ld_val(ld_val),
    .rd_data(rd_data)
  );

  cal_time_core u_time (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick),
    .ld_sec(ld[REG_SEC]), .ld_min(ld[REG_MIN]), .ld_hour(ld[REG_HOUR]),
    .ld_val(ld_val), .sec(sec_q), .min(min_q), .hour(hour_q), .day_tick(day_tick)
  );

  cal_date_core u_date (
    .clk(clk), .rst_n(rst_n), .day_tick(day_tick),
    .ld_date(ld[REG_DATE]), .ld_month(ld[REG_MONTH]), .ld_year(ld[REG_YEAR]),
    .ld_dow(ld[REG_DOW]), .ld_val(ld_val),
    .date(date_q), .month(month_q), .year(year_q), .dow(dow_q)
  );
endmodule

// File: rtl/calendar_clock_checker.sv
module calendar_clock_checker
  import cal_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_valid,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               halted,
  input logic               sec_tick,
  input logic [FIELD_W-1:0] sec,
  input logic [FIELD_W-1:0] min,
  input logic [FIELD_W-1:0] hour,
  input logic [FIELD_W-1:0] date,
  input logic [FIELD_W-1:0] month,
  input logic [FIELD_W-1:0] year,
  input logic [FIELD_W-1:0] dow
);
  AST_FROZEN_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !wr_valid |=> $stable(sec) && $stable(min) && $stable(hour) && $stable(date) && $stable(dow)); // R2
  AST_TIME_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && (wr_addr != REG_CTRL) |=> !halted); // R2
  AST_CTRL_WRITE_KEEPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted && wr_valid && (wr_addr == REG_CTRL) |=> halted); // R2
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && (sec < 7'd59) |=> sec == $past(sec) + 7'd1); // R3
  AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec <= 7'd59) && (min <= 7'd59) && (hour <= 7'd23)); // R5
  AST_SHORT_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
    (month == 7'd4) || (month == 7'd6) || (month == 7'd9) || (month == 7'd11) |-> date <= 7'd30); // R6
  AST_FEB_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    month == 7'd2 |-> date <= ((year[1:0] == 2'b00) ? 7'd29 : 7'd28)); // R7
  AST_DOW_WITH_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && (sec == 7'd59) && (min == 7'd59) && (hour == 7'd23)
    |=> (hour == 7'd0) && (dow == (($past(dow) == 7'd6) ? 7'd0 : $past(dow) + 7'd1))); // R8
  AST_NO_ADVANCE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sec_tick); // R12
endmodule

bind calendar_clock calendar_clock_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .halted(halted), .sec_tick(sec_tick), .sec(sec_q), .min(min_q), .hour(hour_q),
  .date(date_q), .month(month_q), .year(year_q), .dow(dow_q)
);

// File: tb/calendar_clock_tb.sv
`timescale 1ns/1ps
module calendar_clock_tb;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       halted;
  logic       scan = 1'b1;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_sec, m_min, m_hour, m_date, m_month, m_year, m_dow, m_mode, m_halt, m_div;

  calendar_clock #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .halted(halted)
  );

  always #4 clk = ~clk;

  function automatic int to_bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  function automatic int from_bcd(int d);
    return (d / 16) * 10 + (d % 16);
  endfunction

  function automatic int days_of(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int model_read(int a);
    int h12;
    case (a)
      0: return to_bcd(m_sec);
      1: return to_bcd(m_min);
      2: begin
        if (m_mode == 0) return to_bcd(m_hour);
        h12 = (m_hour % 12 == 0) ? 12 : m_hour % 12;
        return to_bcd(h12) + ((m_hour >= 12) ? 32 : 0);
      end
      3: return to_bcd(m_date);
      4: return to_bcd(m_month);
      5: return to_bcd(m_year);
      6: return to_bcd(m_dow);
      default: return m_mode;
    endcase
  endfunction

  task automatic model_advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hour++;
    if (m_hour < 24) return;
    m_hour = 0;
    m_dow = (m_dow + 1) % 7;
    if (m_date < days_of(m_month, m_year)) begin m_date++; return; end
    m_date = 1;
    if (m_month < 12) begin m_month++; return; end
    m_month = 1;
    m_year = (m_year + 1) % 100;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hour = 0; m_date = 1; m_month = 1; m_year = 0;
      m_dow = 0; m_mode = 0; m_halt = 1; m_div = 0;
    end else if (wr_valid) begin
      m_div = 0;
      if (wr_addr != 3'd7) m_halt = 0;
      case (wr_addr)
        3'd0: m_sec = from_bcd(int'(wr_data));
        3'd1: m_min = from_bcd(int'(wr_data));
        3'd2: if (m_mode == 0) m_hour = from_bcd(int'(wr_data));
              else m_hour = (from_bcd(int'(wr_data[4:0])) % 12) + (wr_data[5] ? 12 : 0);
        3'd3: m_date = from_bcd(int'(wr_data));
        3'd4: m_month = from_bcd(int'(wr_data));
        3'd5: m_year = from_bcd(int'(wr_data));
        3'd6: m_dow = from_bcd(int'(wr_data));
        default: m_mode = int'(wr_data[0]);
      endcase
    end else if (ref_tick && m_halt == 0) begin
      if (m_div == DIV - 1) begin m_div = 0; model_advance(); end
      else m_div++;
    end
  end

  // per-cycle comparison against the model, away from the clock edge (R11)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(rd_data) != model_read(int'(rd_addr))) begin
        errors++;
        $display("FAIL R11 model addr=%0d actual=%02h expected=%02h", rd_addr, rd_data, model_read(int'(rd_addr)));
      end
      checks++;
      if (int'(halted) != m_halt) begin
        errors++;
        $display("FAIL R2 model halted actual=%0d expected=%0d", halted, m_halt);
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (scan) rd_addr <= rd_addr + 3'd1;
  end

  task automatic step(int n);
    scan = 1'b1;
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, logic [7:0] exp, string tag);
    scan = 1'b0;
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rd_data, exp);
    end
  endtask

  task automatic check_bit(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic last_second();
    wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    step(DIV);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    peek(3'd0, 8'h00, "R1 sec");   peek(3'd1, 8'h00, "R1 min");
    peek(3'd2, 8'h00, "R1 hour");  peek(3'd3, 8'h01, "R1 date");
    peek(3'd4, 8'h01, "R1 month"); peek(3'd5, 8'h00, "R1 year");
    peek(3'd6, 8'h00, "R1 dow");   peek(3'd7, 8'h00, "R1 ctrl");
    check_bit(halted, 1'b1, "R1 halted");
    // R2 hold-off
    step(40);
    peek(3'd0, 8'h00, "R2 frozen sec");
    wr(3'd7, 8'h00);
    check_bit(halted, 1'b1, "R2 ctrl write keeps hold");
    step(10);
    peek(3'd0, 8'h00, "R2 still frozen");
    wr(3'd0, 8'h58);
    check_bit(halted, 1'b0, "R2 time write releases");
    // R4 divider restart
    step(DIV - 1);
    peek(3'd0, 8'h58, "R4 before full second");
    step(1);
    peek(3'd0, 8'h59, "R4 one second after write");
    step(DIV);
    peek(3'd0, 8'h00, "R5 sec wrap");
    peek(3'd1, 8'h01, "R5 min carry");
    // R3 no advance without reference ticks
    ref_tick = 1'b0;
    step(20);
    peek(3'd0, 8'h00, "R3 no ref no advance");
    ref_tick = 1'b1;
    step(DIV);
    peek(3'd0, 8'h01, "R3 DIV refs per second");
    // R5 R7 R8 full wrap at year end
    wr(3'd6, 8'h06); wr(3'd5, 8'h99); wr(3'd4, 8'h12); wr(3'd3, 8'h31);
    last_second();
    peek(3'd2, 8'h00, "R5 hour wrap"); peek(3'd3, 8'h01, "R5 date wrap");
    peek(3'd4, 8'h01, "R6 month wrap"); peek(3'd5, 8'h00, "R7 year wrap");
    peek(3'd6, 8'h00, "R8 dow wrap");
    // R6 thirty-day month
    wr(3'd4, 8'h04); wr(3'd3, 8'h30);
    last_second();
    peek(3'd4, 8'h05, "R6 april end month"); peek(3'd3, 8'h01, "R6 april end date");
    // R7 leap and common February
    wr(3'd5, 8'h24); wr(3'd4, 8'h02); wr(3'd3, 8'h28);
    last_second();
    peek(3'd3, 8'h29, "R7 leap feb 29");
    last_second();
    peek(3'd4, 8'h03, "R7 leap march"); peek(3'd3, 8'h01, "R7 leap march 1");
    wr(3'd5, 8'h23); wr(3'd4, 8'h02); wr(3'd3, 8'h28);
    last_second();
    peek(3'd4, 8'h03, "R7 common march"); peek(3'd3, 8'h01, "R7 common march 1");
    // R10 twelve-hour form
    wr(3'd7, 8'h01);
    peek(3'd2, 8'h12, "R10 midnight");
    wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59); step(DIV);
    peek(3'd2, 8'h32, "R10 noon flag");
    wr(3'd2, 8'h32); wr(3'd1, 8'h59); wr(3'd0, 8'h59); step(DIV);
    peek(3'd2, 8'h21, "R10 one pm");
    wr(3'd2, 8'h31); wr(3'd1, 8'h59); wr(3'd0, 8'h59); step(DIV);
    peek(3'd2, 8'h12, "R10 back to am");
    peek(3'd3, 8'h02, "R5 date after pm wrap");
    peek(3'd6, 8'h05, "R8 dow count");
    // R9 twenty-four-hour form
    wr(3'd7, 8'h00);
    peek(3'd2, 8'h00, "R9 midnight");
    wr(3'd2, 8'h13);
    peek(3'd2, 8'h13, "R9 hour 13");
    wr(3'd7, 8'h01);
    peek(3'd2, 8'h21, "R10 convert 13");
    peek(3'd7, 8'h01, "R11 ctrl readback");
    // R12 write burst longer than a second
    wr_valid = 1'b1; wr_addr = 3'd0; wr_data = 8'h10;
    repeat (3 * DIV) @(posedge clk);
    #1 wr_valid = 1'b0;
    peek(3'd0, 8'h10, "R12 burst sec");
    peek(3'd1, 8'h00, "R12 burst min");
    check_bit(wr_ready, 1'b1, "R12 ready");
    step(8);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule